// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switch Network

This block is an eight-port packet switch. It is built as a chain of three stages of 2x2 switch cells, with a perfect-shuffle permutation in front of every stage. Each input port presents, in the same cycle, a valid flag, a destination address, a broadcast request bit and a data word. The packet then steers itself through the network. Every stage reads one destination bit, starting with the most significant. A zero sends the packet to the upper output of its cell and a one sends it to the lower output. Every packet that survives is registered at the output port equal to its destination, one clock after it entered, together with the index of the port it came from.

Each cell picks one of four modes. `CELL_PASS` connects upper to upper and lower to lower. `CELL_SWAP` crosses the two. `CELL_BC_UP` copies the upper input to both outputs. `CELL_BC_LO` copies the lower input to both outputs. Mode selection is stateless: the cell moves from one mode to any other in every cycle, as its inputs change. Packets change position at two points. The shuffle rotates the position index left by one bit. The cell replaces the lowest position bit with the destination bit that the stage reads.

The network is partially blocking. When two packets in one cell want the same output, the packet on the upper input keeps it. The other packet is dropped, and its source port raises `blocked` for that cycle. A broadcast request is served only in the first stage. There it fans a packet out to the two ports whose addresses differ only in the top bit. Software that sends packets through the network reads `blocked` to decide what to send again.

Top module: `shuffle_xnet`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `out_src`, `out_data` and `blocked` are all zero, even with valid inputs applied.
- R2: Outputs reflect only the inputs sampled at the previous clock edge. A cycle with no valid input is followed by a cycle with `out_valid` all zero.
- R3: A unicast packet that is not blocked, from input s with destination d, appears on output port d with the same data and with `out_src` equal to s. Destination d is the 3-bit field at bits [3d'+2:3d'] of `in_dest` for input d'. `out_src` and `out_data` are packed the same way, by output port.
- R4: Input i and input i+4 (i < 4) share a first-stage cell, and input i sits on the upper input. If both are valid unicast packets with equal destination MSBs, input i+4 is blocked and input i is delivered.
- R5: The identity permutation (destination = source) and the bit-complement permutation (destination = 7 - source) both pass with no packet blocked.
- R6: When all eight inputs target destination 0, only input 0 is delivered and `blocked` equals 8'hFE.
- R7: Packets with different destinations can still collide in a later stage. Input 0 to destination 0 and input 2 to destination 1 collide in the second stage, so input 2 is blocked.
- R8: `blocked` is never set for an input that was not valid. Every valid unicast packet is either delivered to exactly one port or blocked, never both. For any set of unicast packets, the blocked set follows the rules above: most significant bit first, 0 up and 1 down, rotate-left shuffle before each stage, upper input wins.
- R9: A valid input with its broadcast bit set, whose first-stage partner (see R4) is idle, is delivered to both ports {0,d[1:0]} and {1,d[1:0]}, with `out_src` equal to its own index.
- R10: A broadcast request whose first-stage partner is valid is blocked. A partner that is a unicast packet is routed normally.
- R11: The broadcast bit of an input whose valid flag is low has no effect. It neither blocks its partner nor produces output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Per-input packet present flag |
| in_bcast | input | 8 | Per-input broadcast request (first stage fan-out) |
| in_dest | input | 24 | Per-input 3-bit destination, input k at bits [3k+2:3k] |
| in_data | input | 64 | Per-input 8-bit payload, input k at bits [8k+7:8k] |
| out_valid | output | 8 | Per-output packet delivered flag (registered) |
| out_src | output | 24 | Per-output source port index of the delivered packet |
| out_data | output | 64 | Per-output payload of the delivered packet |
| blocked | output | 8 | Per-input flag: this input's packet lost an output in some cell |

## Verification
The bench builds the network with its default values: a 3-bit address, which gives eight ports and three stages, and an 8-bit payload. At this size every first-stage pairing, every later-stage collision and the all-to-one worst case can be written out by hand in a short vector table. It is also small enough that forty random permutations with random valid masks can be run against a path-tracing reference that follows each packet's link position stage by stage. The broadcast modes are checked in both cell positions, together with the rule that an idle input's broadcast bit has no effect.

// File: rtl/sxn_pkg.sv
package sxn_pkg;

    // Switching mode of one 2x2 cell.
    typedef enum logic [1:0] {
        CELL_PASS  = 2'd0,
        CELL_SWAP  = 2'd1,
        CELL_BC_UP = 2'd2,
        CELL_BC_LO = 2'd3
    } cell_mode_e;

    // Perfect-shuffle position: rotate a w-bit index left by one.
    function automatic int rotl_idx(input int idx, input int w);
        return ((idx << 1) | (idx >> (w - 1))) & ((1 << w) - 1);
    endfunction

endpackage

// File: rtl/sxn_cell.sv
module sxn_cell
    import sxn_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int SEL_BIT  = 2,
    parameter bit BCAST_EN = 1'b0
) (
    input  logic              up_v,
    input  logic              up_bc,
    input  logic [ADDR_W-1:0] up_dst,
    input  logic [ADDR_W-1:0] up_src,
    input  logic [DATA_W-1:0] up_dat,
    input  logic              lo_v,
    input  logic              lo_bc,
    input  logic [ADDR_W-1:0] lo_dst,
    input  logic [ADDR_W-1:0] lo_src,
    input  logic [DATA_W-1:0] lo_dat,
    output logic              o_up_v,
    output logic [ADDR_W-1:0] o_up_dst,
    output logic [ADDR_W-1:0] o_up_src,
    output logic [DATA_W-1:0] o_up_dat,
    output logic              o_lo_v,
    output logic [ADDR_W-1:0] o_lo_dst,
    output logic [ADDR_W-1:0] o_lo_src,
    output logic [DATA_W-1:0] o_lo_dat,
    output logic              drop_up,
    output logic              drop_lo
);

    logic       up_wants_bc;
    logic       lo_wants_bc;
    logic       up_keep;
    logic       lo_keep;
    logic       up_bit;
    logic       lo_bit;
    cell_mode_e mode;

    assign up_wants_bc = up_v & up_bc & BCAST_EN;
    assign lo_wants_bc = lo_v & lo_bc & BCAST_EN;
    assign up_bit      = up_dst[SEL_BIT];
    assign lo_bit      = lo_dst[SEL_BIT];

    // Mode decision: fan-out, drops, then steering of survivors.
    always_comb begin
        mode    = CELL_PASS;
        drop_up = 1'b0;
        drop_lo = 1'b0;
        up_keep = up_v;
        lo_keep = lo_v;
        if (up_wants_bc && !lo_v) begin
            mode = CELL_BC_UP;
        end else if (lo_wants_bc && !up_v) begin
            mode = CELL_BC_LO;
        end else begin
            if (up_wants_bc) begin
                drop_up = 1'b1;
                up_keep = 1'b0;
            end
            if (lo_wants_bc) begin
                drop_lo = 1'b1;
                lo_keep = 1'b0;
            end
            if (up_keep && lo_keep && (up_bit == lo_bit)) begin
                drop_lo = 1'b1;
                lo_keep = 1'b0;
            end
            if (up_keep) begin
                mode = up_bit ? CELL_SWAP : CELL_PASS;
            end else if (lo_keep) begin
                mode = lo_bit ? CELL_PASS : CELL_SWAP;
            end
        end
    end

    // Output steering per mode.
    always_comb begin
        unique case (mode)
            CELL_PASS: begin
                o_up_v   = up_keep;
                o_up_dst = up_dst;
                o_up_src = up_src;
                o_up_dat = up_dat;
                o_lo_v   = lo_keep;
                o_lo_dst = lo_dst;
                o_lo_src = lo_src;
                o_lo_dat = lo_dat;
            end
            CELL_SWAP: begin
                o_up_v   = lo_keep;
                o_up_dst = lo_dst;
                o_up_src = lo_src;
                o_up_dat = lo_dat;
                o_lo_v   = up_keep;
                o_lo_dst = up_dst;
                o_lo_src = up_src;
                o_lo_dat = up_dat;
            end
            CELL_BC_UP: begin
                o_up_v   = 1'b1;
                o_up_dst = up_dst;
                o_up_src = up_src;
                o_up_dat = up_dat;
                o_lo_v   = 1'b1;
                o_lo_dst = up_dst;
                o_lo_src = up_src;
                o_lo_dat = up_dat;
            end
            CELL_BC_LO: begin
                o_up_v   = 1'b1;
                o_up_dst = lo_dst;
                o_up_src = lo_src;
                o_up_dat = lo_dat;
                o_lo_v   = 1'b1;
                o_lo_dst = lo_dst;
                o_lo_src = lo_src;
                o_lo_dat = lo_dat;
            end
            default: begin
                o_up_v   = 1'b0;
                o_up_dst = '0;
                o_up_src = '0;
                o_up_dat = '0;
                o_lo_v   = 1'b0;
                o_lo_dst = '0;
                o_lo_src = '0;
                o_lo_dat = '0;
            end
        endcase
    end

endmodule

// File: rtl/sxn_stage.sv
module sxn_stage
    import sxn_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int STAGE_IDX = 0,
    localparam int N        = 1 << ADDR_W
) (
    input  logic [N-1:0]             in_v,
    input  logic [N-1:0]             in_bc,
    input  logic [N-1:0][ADDR_W-1:0] in_dst,
    input  logic [N-1:0][ADDR_W-1:0] in_src,
    input  logic [N-1:0][DATA_W-1:0] in_dat,
    output logic [N-1:0]             out_v,
    output logic [N-1:0][ADDR_W-1:0] out_dst,
    output logic [N-1:0][ADDR_W-1:0] out_src,
    output logic [N-1:0][DATA_W-1:0] out_dat,
    output logic [N-1:0]             drop_mask
);

    localparam int  CELLS    = N / 2;
    localparam int  SEL_BIT  = ADDR_W - 1 - STAGE_IDX;
    localparam bit  BCAST_EN = (STAGE_IDX == 0);

    logic              sh_v   [N];
    logic              sh_bc  [N];
    logic [ADDR_W-1:0] sh_dst [N];
    logic [ADDR_W-1:0] sh_src [N];
    logic [DATA_W-1:0] sh_dat [N];

    logic              co_v   [N];
    logic [ADDR_W-1:0] co_dst [N];
    logic [ADDR_W-1:0] co_src [N];
    logic [DATA_W-1:0] co_dat [N];

    logic cd_up [CELLS];
    logic cd_lo [CELLS];

    // Perfect shuffle in front of the cell column.
    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int P = rotl_idx(i, ADDR_W);
        assign sh_v[P]   = in_v[i];
        assign sh_bc[P]  = in_bc[i];
        assign sh_dst[P] = in_dst[i];
        assign sh_src[P] = in_src[i];
        assign sh_dat[P] = in_dat[i];
    end

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        sxn_cell #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .SEL_BIT  (SEL_BIT),
            .BCAST_EN (BCAST_EN)
        ) cell_i (
            .up_v     (sh_v[2*c]),
            .up_bc    (sh_bc[2*c]),
            .up_dst   (sh_dst[2*c]),
            .up_src   (sh_src[2*c]),
            .up_dat   (sh_dat[2*c]),
            .lo_v     (sh_v[2*c+1]),
            .lo_bc    (sh_bc[2*c+1]),
            .lo_dst   (sh_dst[2*c+1]),
            .lo_src   (sh_src[2*c+1]),
            .lo_dat   (sh_dat[2*c+1]),
            .o_up_v   (co_v[2*c]),
            .o_up_dst (co_dst[2*c]),
            .o_up_src (co_src[2*c]),
            .o_up_dat (co_dat[2*c]),
            .o_lo_v   (co_v[2*c+1]),
            .o_lo_dst (co_dst[2*c+1]),
            .o_lo_src (co_src[2*c+1]),
            .o_lo_dat (co_dat[2*c+1]),
            .drop_up  (cd_up[c]),
            .drop_lo  (cd_lo[c])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            out_v[i]   = co_v[i];
            out_dst[i] = co_dst[i];
            out_src[i] = co_src[i];
            out_dat[i] = co_dat[i];
        end
    end

    // Map cell drops back to the source ports that lost.
    always_comb begin
        drop_mask = '0;
        for (int c = 0; c < CELLS; c++) begin
            if (cd_up[c]) drop_mask[sh_src[2*c]]   = 1'b1;
            if (cd_lo[c]) drop_mask[sh_src[2*c+1]] = 1'b1;
        end
    end

endmodule

// File: rtl/shuffle_xnet.sv
module shuffle_xnet #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int N     = 1 << ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          in_valid,
    input  logic [N-1:0]          in_bcast,
    input  logic [N*ADDR_W-1:0]   in_dest,
    input  logic [N*DATA_W-1:0]   in_data,
    output logic [N-1:0]          out_valid,
    output logic [N*ADDR_W-1:0]   out_src,
    output logic [N*DATA_W-1:0]   out_data,
    output logic [N-1:0]          blocked
);

    localparam int STAGES = ADDR_W;

    logic [N-1:0]             ch_v    [STAGES+1];
    logic [N-1:0][ADDR_W-1:0] ch_dst  [STAGES+1];
    logic [N-1:0][ADDR_W-1:0] ch_src  [STAGES+1];
    logic [N-1:0][DATA_W-1:0] ch_dat  [STAGES+1];
    logic [N-1:0]             ch_drop [STAGES];
    logic [N-1:0][ADDR_W-1:0] src_tag;

    logic [N-1:0]             v_nxt;
    logic [N-1:0][ADDR_W-1:0] src_nxt;
    logic [N-1:0][DATA_W-1:0] dat_nxt;
    logic [N-1:0]             blk_nxt;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            src_tag[i] = ADDR_W'(i);
        end
    end

    assign ch_v[0]   = in_valid;
    assign ch_dst[0] = in_dest;
    assign ch_src[0] = src_tag;
    assign ch_dat[0] = in_data;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        sxn_stage #(
            .ADDR_W    (ADDR_W),
            .DATA_W    (DATA_W),
            .STAGE_IDX (k)
        ) stage_i (
            .in_v      (ch_v[k]),
            .in_bc     ((k == 0) ? in_bcast : '0),
            .in_dst    (ch_dst[k]),
            .in_src    (ch_src[k]),
            .in_dat    (ch_dat[k]),
            .out_v     (ch_v[k+1]),
            .out_dst   (ch_dst[k+1]),
            .out_src   (ch_src[k+1]),
            .out_dat   (ch_dat[k+1]),
            .drop_mask (ch_drop[k])
        );
    end

    // Next-output process: collect drops, clean idle lanes.
    always_comb begin
        blk_nxt = '0;
        for (int k = 0; k < STAGES; k++) begin
            blk_nxt = blk_nxt | ch_drop[k];
        end
        v_nxt = ch_v[STAGES];
        for (int i = 0; i < N; i++) begin
            src_nxt[i] = ch_v[STAGES][i] ? ch_src[STAGES][i] : '0;
            dat_nxt[i] = ch_v[STAGES][i] ? ch_dat[STAGES][i] : '0;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_src   <= '0;
            out_data  <= '0;
            blocked   <= '0;
        end else begin
            out_valid <= v_nxt;
            out_src   <= src_nxt;
            out_data  <= dat_nxt;
            blocked   <= blk_nxt;
        end
    end

endmodule

// File: rtl/sxn_chk.sv
module sxn_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int N     = 1 << ADDR_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N-1:0]          in_valid,
    input logic [N-1:0]          in_bcast,
    input logic [N*ADDR_W-1:0]   in_dest,
    input logic [N*DATA_W-1:0]   in_data,
    input logic [N-1:0]          out_valid,
    input logic [N*ADDR_W-1:0]   out_src,
    input logic [N*DATA_W-1:0]   out_data,
    input logic [N-1:0]          blocked
);

    logic [N-1:0]             pv;
    logic [N-1:0]             pbc;
    logic [N-1:0][ADDR_W-1:0] pdst;
    logic [N-1:0][DATA_W-1:0] pdat;
    logic [N-1:0][ADDR_W-1:0] osrc;
    logic [N-1:0][DATA_W-1:0] odat;

    assign osrc = out_src;
    assign odat = out_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv   <= '0;
            pbc  <= '0;
            pdst <= '0;
            pdat <= '0;
        end else begin
            pv   <= in_valid;
            pbc  <= in_bcast;
            pdst <= in_dest;
            pdat <= in_data;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pv == '0) |-> (out_valid == '0 && blocked == '0)); // R2

    AST_LONE_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pv) == 1 && (pv & pbc) == '0) |-> (blocked == '0 && $countones(out_valid) == 1)); // R8

    for (genvar j = 0; j < N; j++) begin : g_out
        localparam logic [ADDR_W-1:0] JJ = ADDR_W'(j);
        AST_ROUTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (pv[osrc[j]] &&
                (pbc[osrc[j]] ? (pdst[osrc[j]][ADDR_W-2:0] == JJ[ADDR_W-2:0])
                              : (pdst[osrc[j]] == JJ)))); // R3
        AST_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (odat[j] == pdat[osrc[j]])); // R3
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        localparam logic [ADDR_W-1:0] II = ADDR_W'(i);
        AST_BLOCK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            blocked[i] |-> pv[i]); // R8
        AST_UNICAST_FATE: assert property (@(posedge clk) disable iff (!rst_n)
            (pv[i] && !pbc[i]) |-> (blocked[i] ^ (out_valid[pdst[i]] && osrc[pdst[i]] == II))); // R8
    end

endmodule

bind shuffle_xnet sxn_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/shuffle_xnet_tb_top.sv
module shuffle_xnet_tb_top;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NP = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP-1:0]   in_bcast = '0;
    logic [NP*AW-1:0] in_dest = '0;
    logic [NP*DW-1:0] in_data = '0;
    logic [NP-1:0]   out_valid;
    logic [NP*AW-1:0] out_src;
    logic [NP*DW-1:0] out_data;
    logic [NP-1:0]   blocked;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [NP-1:0] e_v;
    logic [NP-1:0] e_blk;
    logic [AW-1:0] e_src [NP];
    logic [7:0]    cur_tag;

    always #4 clk = ~clk;

    shuffle_xnet #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bcast  (in_bcast),
        .in_dest   (in_dest),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_src   (out_src),
        .out_data  (out_data),
        .blocked   (blocked)
    );

    // Vector table: {valid mask, destinations (input k at [3k+2:3k]), expected blocked}.
    localparam int NV = 7;
    localparam logic [39:0] VEC [NV] = '{
        {8'hFF, 24'hFAC688, 8'h00},   // R5 identity
        {8'hFF, 24'h053977, 8'h00},   // R5 complement
        {8'hFF, 24'h000000, 8'hFE},   // R6 all to port 0
        {8'h11, 24'h000001, 8'h10},   // R4 same MSB in first cell
        {8'h11, 24'h004000, 8'h00},   // R4 different MSB
        {8'h05, 24'h000040, 8'h04},   // R7 later-stage collision
        {8'h00, 24'h000000, 8'h00}    // R2 idle cycle
    };
    localparam string VREQ [NV] = '{"R5", "R5", "R6", "R4", "R4", "R7", "R2"};

    function automatic logic [DW-1:0] dat_of(input int s, input logic [7:0] tag);
        return DW'((s * 37 + int'(tag) * 11 + 5) & 255);
    endfunction

    // Path-tracing reference: link position per stage, upper (even) entry wins.
    function automatic logic [NP-1:0] model_blk(input logic [NP-1:0] vm, input logic [NP*AW-1:0] dl);
        int pos [NP];
        int ent [NP];
        logic [NP-1:0] alive;
        logic [NP-1:0] lost;
        logic [NP-1:0] blk;
        alive = vm;
        blk = '0;
        for (int s = 0; s < NP; s++) pos[s] = s;
        for (int k = 0; k < AW; k++) begin
            lost = '0;
            for (int s = 0; s < NP; s++) ent[s] = ((pos[s] << 1) | (pos[s] >> (AW - 1))) & (NP - 1);
            for (int s = 0; s < NP; s++) begin
                for (int t = s + 1; t < NP; t++) begin
                    if (alive[s] && alive[t] && ((ent[s] >> 1) == (ent[t] >> 1)) &&
                        (dl[AW*s + AW-1-k] == dl[AW*t + AW-1-k])) begin
                        if (ent[s] & 1) lost[s] = 1'b1;
                        else lost[t] = 1'b1;
                    end
                end
            end
            alive = alive & ~lost;
            blk = blk | lost;
            for (int s = 0; s < NP; s++) pos[s] = (ent[s] & (NP - 2)) | int'(dl[AW*s + AW-1-k]);
        end
        return blk;
    endfunction

    task automatic check(input bit ok, input string req, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    task automatic drive(input logic [NP-1:0] vm, input logic [NP-1:0] bm,
                         input logic [NP*AW-1:0] dl, input logic [7:0] tag);
        @(negedge clk);
        in_valid = vm;
        in_bcast = bm;
        in_dest  = dl;
        cur_tag  = tag;
        for (int s = 0; s < NP; s++) in_data[DW*s +: DW] = dat_of(s, tag);
    endtask

    task automatic clear_exp();
        e_v = '0;
        e_blk = '0;
        for (int p = 0; p < NP; p++) e_src[p] = '0;
    endtask

    task automatic unicast_exp(input logic [NP-1:0] vm, input logic [NP*AW-1:0] dl,
                               input logic [NP-1:0] blk);
        clear_exp();
        e_blk = blk;
        for (int s = 0; s < NP; s++) begin
            if (vm[s] && !blk[s]) begin
                e_v[dl[AW*s +: AW]] = 1'b1;
                e_src[dl[AW*s +: AW]] = AW'(s);
            end
        end
    endtask

    // Sample one full cycle after driving.
    task automatic compare(input string req);
        @(negedge clk);
        check(out_valid == e_v, req, $sformatf("out_valid actual=%h expected=%h", out_valid, e_v));
        check(blocked == e_blk, req, $sformatf("blocked actual=%h expected=%h", blocked, e_blk));
        for (int p = 0; p < NP; p++) begin
            if (e_v[p]) begin
                check(out_src[AW*p +: AW] == e_src[p] &&
                      out_data[DW*p +: DW] == dat_of(int'(e_src[p]), cur_tag), req,
                      $sformatf("port %0d src/data actual=%0d/%h expected=%0d/%h", p,
                                out_src[AW*p +: AW], out_data[DW*p +: DW],
                                e_src[p], dat_of(int'(e_src[p]), cur_tag)));
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        cur_tag = 8'd0;
        // R1: reset holds outputs low with busy inputs.
        drive(8'hFF, 8'h00, 24'hFAC688, 8'd1);
        repeat (2) @(negedge clk);
        check(out_valid == '0 && blocked == '0 && out_src == '0 && out_data == '0, "R1",
              $sformatf("reset outputs actual=%h/%h expected=0/0", out_valid, blocked));
        in_valid = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == '0 && blocked == '0, "R1",
              $sformatf("after release actual=%h/%h expected=0/0", out_valid, blocked));

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            logic [NP-1:0]    vm;
            logic [NP*AW-1:0] dl;
            logic [NP-1:0]    xb;
            vm = VEC[v][39:32];
            dl = VEC[v][31:8];
            xb = VEC[v][7:0];
            check(model_blk(vm, dl) == xb, "R8",
                  $sformatf("reference vs table row %0d actual=%h expected=%h", v, model_blk(vm, dl), xb));
            drive(vm, 8'h00, dl, 8'(v + 2));
            unicast_exp(vm, dl, xb);
            compare(VREQ[v]);
        end

        // R9: upper broadcast, input 1 to d=3 -> ports 3 and 7.
        drive(8'h02, 8'h02, 24'h000018, 8'd20);
        clear_exp();
        e_v[3] = 1'b1; e_src[3] = 3'd1;
        e_v[7] = 1'b1; e_src[7] = 3'd1;
        compare("R9");
        // R9: lower broadcast, input 6 to d=0 -> ports 0 and 4.
        drive(8'h40, 8'h40, 24'h000000, 8'd21);
        clear_exp();
        e_v[0] = 1'b1; e_src[0] = 3'd6;
        e_v[4] = 1'b1; e_src[4] = 3'd6;
        compare("R9");
        // R10: broadcast input 1 with valid partner 5 (d=6).
        drive(8'h22, 8'h02, 24'h030018, 8'd22);
        clear_exp();
        e_blk = 8'h02;
        e_v[6] = 1'b1; e_src[6] = 3'd5;
        compare("R10");
        // R11: broadcast bit on idle input 1; partner 5 (d=2) delivered.
        drive(8'h20, 8'h02, 24'h010000, 8'd23);
        clear_exp();
        e_v[2] = 1'b1; e_src[2] = 3'd5;
        compare("R11");
        // R11: broadcast bits with nothing valid.
        drive(8'h00, 8'hFF, 24'h000000, 8'd24);
        clear_exp();
        compare("R11");

        // R8: random permutations with random valid masks.
        lfsr = 16'hACE1;
        for (int it = 0; it < 40; it++) begin
            int perm [NP];
            logic [NP-1:0]    vm;
            logic [NP*AW-1:0] dl;
            for (int s = 0; s < NP; s++) perm[s] = s;
            for (int s = NP - 1; s > 0; s--) begin
                int j;
                int tmp;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                j = int'(lfsr) % (s + 1);
                tmp = perm[s];
                perm[s] = perm[j];
                perm[j] = tmp;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            vm = (it % 4 == 0) ? 8'hFF : lfsr[7:0];
            for (int s = 0; s < NP; s++) dl[AW*s +: AW] = AW'(perm[s]);
            drive(vm, 8'h00, dl, 8'(it + 40));
            unicast_exp(vm, dl, model_blk(vm, dl));
            compare("R8");
        end

        // R2: idle cycle after traffic clears outputs.
        drive(8'h00, 8'h00, 24'h000000, 8'd99);
        clear_exp();
        compare("R2");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule